// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Master

This block drives a small three-wire serial EEPROM of 64 sixteen-bit words. A host sends one request at a time on a valid/ready port. Each request carries an operation code, a word address and write data. The block turns the request into a 10-bit command sent most significant bit first, with a 16-bit data phase where the operation needs one. It generates the chip select, serial clock and serial data lines itself and samples the device's serial output. After a write or erase it polls the device until the device reports ready.

The request port applies back-pressure through `req_ready`, which is high only while the block is idle. A request is taken on a cycle where `req_valid` and `req_ready` are both high. While a command is in progress `req_ready` stays low, and anything presented on the request port is ignored. The result side has no back-pressure. `done` pulses for one cycle when the operation ends, and in that cycle `rsp_rdata` (after a read) and `err_timeout` are valid. Both hold their values until the next request is accepted. The serial clock comes from the system clock through a divider whose setting is latched when the request is accepted.

Top module: `uwire_eeprom_master`

## Requirements
- R1: A request is accepted on a cycle with `req_valid` and `req_ready` both high. `busy` is high from the next cycle, `req_ready` equals the inverse of `busy`, and requests presented while busy are ignored.
- R2: Each command is 10 bits sent MSB first. The frames are: read 0x180|addr, write 0x140|addr, erase 0x1C0|addr, write-all 0x110, erase-all 0x120, write-enable 0x130, write-disable 0x100. The `req_op` codes are 0 read, 1 write, 2 erase, 3 write-all, 4 erase-all, 5 write-enable and 6 write-disable, and code 7 acts as write-disable.
- R3: Each command starts with chip select and serial clock both low for one phase. Chip select then rises with the clock low and stays high through the command bits and any data bits. It is low again after every command.
- R4: For each bit sent, `ee_di` takes its value while the clock is low, and it does not change while the clock is high.
- R5: A read takes in 16 bits MSB first. Each bit is sampled at the end of a low phase that follows a full clock pulse. The word appears on `rsp_rdata` when `done` pulses.
- R6: Write and write-all send 16 data bits MSB first right after the command bits, in the same chip-select window.
- R7: After write, erase, write-all or erase-all, chip select drops for one phase and then rises again with no clock pulses. `ee_do` is sampled once per phase until it reads high.
- R8: If `ee_do` stays low for POLL_LIMIT polling phases, the operation ends with `err_timeout` high. `err_timeout` is cleared when the next request is accepted.
- R9: Every serial-clock high phase and low phase inside a command lasts at least `clk_div`+1 system clock cycles.
- R10: `done` is high for exactly one cycle per accepted request. In that cycle `busy` is already low.
- R11: The serial clock is never high while chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_div | input | DIV_W | Serial clock divider; each phase is clk_div+1 cycles |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 3 | Operation code |
| req_addr | input | 6 | Word address |
| req_wdata | input | DATA_W | Data for write and write-all |
| rsp_rdata | output | DATA_W | Last word read |
| done | output | 1 | One-cycle end-of-operation pulse |
| busy | output | 1 | Operation in progress |
| err_timeout | output | 1 | Last operation timed out while polling |
| ee_cs | output | 1 | Device chip select |
| ee_sk | output | 1 | Device serial clock |
| ee_di | output | 1 | Serial data to device |
| ee_do | input | 1 | Serial data from device |

## Verification
The hardest case to reach from the ports is the polling timeout. A working device always reports ready in the end, so the error path never runs under normal stimulus. The bench's device model has a switch that holds its output low after a write, and the bench instantiates the block with a small POLL_LIMIT so the limit is reached quickly. A read after the timeout then shows the error flag cleared and the write completed. Requests arriving during a command are provoked by holding `req_valid` high with a different opcode while busy. The scoreboard of received frames then shows that no extra command was ever sent.

// File: rtl/uwire_pkg.sv
package uwire_pkg;

  localparam int FRAME_W = 10;
  localparam int ADDR_W  = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHOUT,
    ST_SHIN,
    ST_TAIL,
    ST_REL,
    ST_POLL
  } uw_state_e;

  // command frame for an opcode; address sits in the low bits
  function automatic logic [FRAME_W-1:0] uw_frame(input logic [2:0] op,
                                                 input logic [ADDR_W-1:0] a);
    logic [FRAME_W-1:0] f;
    case (op)
      3'd0:    f = 10'h180 | {4'b0, a};
      3'd1:    f = 10'h140 | {4'b0, a};
      3'd2:    f = 10'h1C0 | {4'b0, a};
      3'd3:    f = 10'h110;
      3'd4:    f = 10'h120;
      3'd5:    f = 10'h130;
      default: f = 10'h100;
    endcase
    return f;
  endfunction

  function automatic logic uw_has_wdata(input logic [2:0] op);
    return (op == 3'd1) || (op == 3'd3);
  endfunction

  function automatic logic uw_needs_poll(input logic [2:0] op);
    return (op >= 3'd1) && (op <= 3'd4);
  endfunction

endpackage

// File: rtl/uwire_tick.sv
module uwire_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/uwire_poll.sv
module uwire_poll #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic tick,
  input  logic ready,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  assign expired = active && tick && !ready && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)                              cnt <= '0;
    else if (!active)                        cnt <= '0;
    else if (tick && cnt != CW'(LIMIT))      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/uwire_seq.sv
module uwire_seq
  import uwire_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_fire,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              tick,
  input  logic              poll_exp,
  input  logic              ee_do,
  output uw_state_e         st,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic              err
);
  localparam int SR_W  = FRAME_W + DATA_W;
  localparam int CNT_W = $clog2(SR_W + 1);

  logic [SR_W-1:0]   out_sr;
  logic [DATA_W-1:0] in_sr;
  logic [CNT_W-1:0]  bcnt, nbits;
  logic [1:0]        sub;
  logic              is_read, poll_pend;

  assign ee_cs = (st == ST_SHOUT) || (st == ST_SHIN) || (st == ST_TAIL) || (st == ST_POLL);
  assign ee_sk = ((st == ST_SHOUT) || (st == ST_SHIN)) && (sub == 2'd1);
  assign ee_di = (st == ST_SHOUT) && out_sr[SR_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      out_sr    <= '0;
      in_sr     <= '0;
      bcnt      <= '0;
      nbits     <= '0;
      sub       <= '0;
      is_read   <= 1'b0;
      poll_pend <= 1'b0;
      rdata     <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == ST_IDLE) begin
        if (req_fire) begin
          st        <= ST_SETUP;
          out_sr    <= {uw_frame(req_op, req_addr), req_wdata};
          nbits     <= uw_has_wdata(req_op) ? CNT_W'(SR_W) : CNT_W'(FRAME_W);
          is_read   <= (req_op == 3'd0);
          poll_pend <= uw_needs_poll(req_op);
          bcnt      <= '0;
          sub       <= '0;
          err       <= 1'b0;
        end
      end else if (tick) begin
        case (st)
          ST_SETUP: begin
            st  <= ST_SHOUT;
            sub <= '0;
          end
          ST_SHOUT: begin
            if (sub == 2'd0) sub <= 2'd1;
            else begin
              sub    <= 2'd0;
              out_sr <= out_sr << 1;
              if (bcnt == nbits - 1'b1) begin
                bcnt <= '0;
                st   <= is_read ? ST_SHIN : ST_TAIL;
              end else begin
                bcnt <= bcnt + 1'b1;
              end
            end
          end
          ST_SHIN: begin
            if (sub != 2'd2) sub <= sub + 1'b1;
            else begin
              sub   <= 2'd0;
              in_sr <= {in_sr[DATA_W-2:0], ee_do};
              if (bcnt == CNT_W'(DATA_W - 1)) begin
                rdata <= {in_sr[DATA_W-2:0], ee_do};
                bcnt  <= '0;
                st    <= ST_REL;
              end else begin
                bcnt <= bcnt + 1'b1;
              end
            end
          end
          ST_TAIL: st <= ST_REL;
          ST_REL: begin
            if (poll_pend) begin
              poll_pend <= 1'b0;
              st        <= ST_POLL;
            end else begin
              st   <= ST_IDLE;
              done <= 1'b1;
            end
          end
          ST_POLL: begin
            if (ee_do) st <= ST_REL;
            else if (poll_exp) begin
              err <= 1'b1;
              st  <= ST_REL;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uwire_eeprom_master.sv
module uwire_eeprom_master
  import uwire_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int DIV_W      = 8,
  parameter int POLL_LIMIT = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [5:0]        req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              done,
  output logic              busy,
  output logic              err_timeout,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do
);
  uw_state_e        st;
  logic [DIV_W-1:0] div_q;
  logic             tick, poll_exp, req_fire, in_poll;

  assign req_ready = (st == ST_IDLE);
  assign busy      = !req_ready;
  assign req_fire  = req_valid && req_ready;
  assign in_poll   = (st == ST_POLL);

  always_ff @(posedge clk) begin
    if (!rst_n)        div_q <= '0;
    else if (req_fire) div_q <= clk_div;
  end

  uwire_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(div_q), .tick(tick)
  );

  uwire_poll #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk(clk), .rst_n(rst_n), .active(in_poll), .tick(tick),
    .ready(ee_do), .expired(poll_exp)
  );

  uwire_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_fire(req_fire), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .tick(tick),
    .poll_exp(poll_exp), .ee_do(ee_do), .st(st), .ee_cs(ee_cs),
    .ee_sk(ee_sk), .ee_di(ee_di), .rdata(rsp_rdata), .done(done),
    .err(err_timeout)
  );
endmodule

// File: rtl/uwire_eeprom_master_chk.sv
module uwire_eeprom_master_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             busy,
  input logic             done,
  input logic             ee_cs,
  input logic             ee_sk,
  input logic             ee_di,
  input logic [DIV_W-1:0] div_q
);
  localparam int RW = DIV_W + 2;
  logic [RW-1:0] run;
  logic          sk_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run     <= '0;
      sk_prev <= 1'b0;
    end else begin
      sk_prev <= ee_sk;
      if (ee_sk != sk_prev)     run <= RW'(1);
      else if (run != {RW{1'b1}}) run <= run + 1'b1;
    end
  end

  assert_phase_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk != sk_prev) |-> (run >= (RW'(div_q) + RW'(1))));

  assert_sk_in_cs_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> ee_cs);

  assert_di_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk && $past(ee_sk)) |-> $stable(ee_di));

  assert_cs_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_cs) |-> !ee_sk);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);
endmodule

bind uwire_eeprom_master uwire_eeprom_master_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .busy(busy), .done(done), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
  .div_q(div_q)
);

// File: tb/uwire_eeprom_master_test.sv
module uwire_eeprom_master_test;
  localparam int BUSY_CYC = 30;
  localparam int PLIM     = 50;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  clk_div = 8'd0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = 3'd0;
  logic [5:0]  req_addr = 6'd0;
  logic [15:0] req_wdata = 16'd0;
  logic [15:0] rsp_rdata;
  logic        done, busy, err_timeout;
  logic        ee_cs, ee_sk, ee_di;
  logic        ee_do = 1'b1;

  always #5 clk = ~clk;

  uwire_eeprom_master #(.DATA_W(16), .DIV_W(8), .POLL_LIMIT(PLIM)) uut (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .req_valid(req_valid),
    .req_ready(req_ready), .req_op(req_op), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .done(done), .busy(busy),
    .err_timeout(err_timeout), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
    .ee_do(ee_do)
  );

  int n_tests = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard queues
  logic [9:0]  q_frame[$];
  int          q_nbits[$];
  bit          q_isrd[$];
  logic [15:0] q_rd[$];
  bit          q_err[$];

  // reference contents
  logic [15:0] rmem[64];
  bit          rwen = 0;

  // device model
  logic [15:0] dmem[64];
  bit          dwen = 0, hang = 0;
  int          edges = 0, busy_cnt = 0;
  logic [9:0]  fr = '0;
  logic [15:0] wd = '0;
  logic        prev_sk = 0, prev_cs = 0, rd_bit = 0;

  always @(negedge clk) begin
    if (busy_cnt > 0) busy_cnt--;
    if (ee_cs && !prev_cs) edges = 0;
    if (ee_cs && ee_sk && !prev_sk) begin
      if (edges < 10) fr = {fr[8:0], ee_di};
      else if (edges < 26) begin
        wd = {wd[14:0], ee_di};
        if (fr[9:6] == 4'b0110) rd_bit = dmem[fr[5:0]][25-edges];
      end
      edges++;
    end
    if (!ee_cs && prev_cs && edges > 0) begin
      if (q_frame.size() == 0) chk(0, "R1 unexpected command", {22'd0, fr}, 0);
      else begin
        logic [9:0] ef;
        int en;
        ef = q_frame.pop_front();
        en = q_nbits.pop_front();
        chk(fr == ef, "R2 frame", {22'd0, fr}, {22'd0, ef});
        chk(edges == en, "R6 clock pulse count", edges, en);
      end
      case (fr[9:6])
        4'b0101: begin if (dwen) dmem[fr[5:0]] = wd; busy_cnt = BUSY_CYC; end
        4'b0111: begin if (dwen) dmem[fr[5:0]] = 16'hFFFF; busy_cnt = BUSY_CYC; end
        4'b0100: case (fr[5:4])
          2'b11: dwen = 1;
          2'b00: dwen = 0;
          2'b01: begin if (dwen) for (int i = 0; i < 64; i++) dmem[i] = wd; busy_cnt = BUSY_CYC; end
          default: begin if (dwen) for (int i = 0; i < 64; i++) dmem[i] = 16'hFFFF; busy_cnt = BUSY_CYC; end
        endcase
        default: ;
      endcase
    end
    if (ee_cs && fr[9:6] == 4'b0110 && edges >= 11) ee_do = rd_bit;
    else ee_do = (busy_cnt == 0) && !hang;
    prev_sk = ee_sk;
    prev_cs = ee_cs;
  end

  // pin-level observers for one operation
  int  sk_run = 0, min_run = 1000, cs_rises = 0, cs_lo_run = 0, min_cs_lo = 1000;
  bit  sk_out_cs = 0, di_moved = 0;
  logic o_sk = 0, o_cs = 0, o_di = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (ee_sk != o_sk) begin
        if (busy && sk_run < min_run) min_run = sk_run;
        sk_run = 1;
      end else sk_run++;
      if (ee_cs && !o_cs) begin
        cs_rises++;
        if (busy && cs_lo_run < min_cs_lo) min_cs_lo = cs_lo_run;
      end
      if (!ee_cs) cs_lo_run++; else cs_lo_run = 0;
      if (ee_sk && !ee_cs) sk_out_cs = 1;
      if (ee_sk && o_sk && ee_di != o_di) di_moved = 1;
    end
    o_sk = ee_sk; o_cs = ee_cs; o_di = ee_di;
  end

  // monitor
  int  done_seen = 0;
  logic prev_done = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        bit isrd, e;
        logic [15:0] r;
        done_seen++;
        chk(!busy && req_ready, "R10 idle at done", {30'd0, busy, req_ready}, 32'h1);
        if (q_isrd.size() == 0) chk(0, "R10 done without request", 1, 0);
        else begin
          isrd = q_isrd.pop_front();
          r = q_rd.pop_front();
          e = q_err.pop_front();
          if (isrd) chk(rsp_rdata == r, "R5 read data", rsp_rdata, r);
          chk(err_timeout == e, "R8 timeout flag", err_timeout, e);
        end
      end
      if (done && prev_done) chk(0, "R10 done wider than one cycle", 1, 0);
    end
    prev_done = done;
  end

  int target = 0;

  task automatic run_op(input logic [2:0] op, input logic [5:0] a, input logic [15:0] w,
                        input logic [7:0] dv, input bit exp_err, input bit poke);
    logic [9:0] f;
    bit poll;
    case (op)
      3'd0: f = 10'h180 | {4'd0, a};
      3'd1: f = 10'h140 | {4'd0, a};
      3'd2: f = 10'h1C0 | {4'd0, a};
      3'd3: f = 10'h110;
      3'd4: f = 10'h120;
      3'd5: f = 10'h130;
      default: f = 10'h100;
    endcase
    poll = (op >= 3'd1 && op <= 3'd4);
    q_frame.push_back(f);
    q_nbits.push_back((op == 3'd0 || op == 3'd1 || op == 3'd3) ? 26 : 10);
    q_isrd.push_back(op == 3'd0);
    q_rd.push_back(rmem[a]);
    q_err.push_back(exp_err);
    case (op)
      3'd1: if (rwen) rmem[a] = w;
      3'd2: if (rwen) rmem[a] = 16'hFFFF;
      3'd3: if (rwen) for (int i = 0; i < 64; i++) rmem[i] = w;
      3'd4: if (rwen) for (int i = 0; i < 64; i++) rmem[i] = 16'hFFFF;
      3'd5: rwen = 1;
      3'd0: ;
      default: rwen = 0;
    endcase
    @(negedge clk);
    min_run = 1000; min_cs_lo = 1000; cs_rises = 0; sk_out_cs = 0; di_moved = 0;
    chk(req_ready == 1'b1, "R1 ready when idle", req_ready, 1);
    clk_div = dv; req_op = op; req_addr = a; req_wdata = w; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R1 busy after accept", busy, 1);
    if (poke) begin
      for (int k = 0; k < 3; k++) begin
        req_op = 3'd4; req_valid = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b0, "R1 not ready while busy", req_ready, 0);
      end
      req_valid = 1'b0;
    end
    target++;
    wait (done_seen == target);
    @(negedge clk);
    chk(min_run >= dv + 1, "R9 clock phase width", min_run, dv + 1);
    chk(cs_rises == (poll ? 2 : 1), "R7 chip select windows", cs_rises, poll ? 2 : 1);
    if (poll) chk(min_cs_lo >= dv + 1, "R7 drop before polling", min_cs_lo, dv + 1);
    chk(!sk_out_cs, "R11 clock outside chip select", sk_out_cs, 0);
    chk(!di_moved, "R4 data held while clock high", di_moved, 0);
    chk(!ee_cs && !ee_sk, "R3 chip select low after command", {30'd0, ee_cs, ee_sk}, 0);
  endtask

  initial begin
    #1_500_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin rmem[i] = 16'hFFFF; dmem[i] = 16'hFFFF; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state, R3 R10
    chk(!ee_cs && !ee_sk && !busy && req_ready && !done, "R3 reset state",
        {27'd0, ee_cs, ee_sk, busy, req_ready, done}, 32'h2);
    // writes disabled: write is dropped by device
    run_op(3'd6, 6'd0, 16'h0, 8'd1, 0, 0);
    run_op(3'd1, 6'd5, 16'h1111, 8'd1, 0, 0);
    run_op(3'd0, 6'd5, 16'h0, 8'd1, 0, 0);
    // enable and write/read at several dividers (R2 R5 R6)
    run_op(3'd5, 6'd0, 16'h0, 8'd0, 0, 1);
    run_op(3'd1, 6'd5, 16'hA5C3, 8'd0, 0, 0);
    run_op(3'd0, 6'd5, 16'h0, 8'd0, 0, 0);
    run_op(3'd1, 6'd63, 16'h8001, 8'd3, 0, 1);
    run_op(3'd0, 6'd63, 16'h0, 8'd3, 0, 0);
    run_op(3'd1, 6'd0, 16'h1234, 8'd2, 0, 0);
    run_op(3'd0, 6'd0, 16'h0, 8'd2, 0, 1);
    // erase, write-all, erase-all
    run_op(3'd2, 6'd5, 16'h0, 8'd1, 0, 0);
    run_op(3'd0, 6'd5, 16'h0, 8'd1, 0, 0);
    run_op(3'd3, 6'd0, 16'h0F0F, 8'd1, 0, 0);
    run_op(3'd0, 6'd17, 16'h0, 8'd1, 0, 0);
    run_op(3'd4, 6'd0, 16'h0, 8'd0, 0, 0);
    run_op(3'd0, 6'd40, 16'h0, 8'd0, 0, 0);
    // code 7 behaves as write-disable (R2)
    run_op(3'd7, 6'd0, 16'h0, 8'd1, 0, 0);
    run_op(3'd1, 6'd3, 16'h0000, 8'd1, 0, 0);
    run_op(3'd0, 6'd3, 16'h0, 8'd1, 0, 0);
    // polling timeout (R8), then flag cleared on next request
    run_op(3'd5, 6'd0, 16'h0, 8'd1, 0, 0);
    hang = 1;
    run_op(3'd1, 6'd9, 16'h5555, 8'd1, 1, 0);
    hang = 0;
    run_op(3'd0, 6'd9, 16'h0, 8'd1, 0, 0);
    repeat (20) @(negedge clk);
    chk(q_frame.size() == 0 && q_isrd.size() == 0, "R1 no extra commands",
        q_frame.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule